// File: doc/BRIEF.md
# Signed Nibble Seven-Segment Digit Driver

This block turns one 4-bit two's complement number into the drive pattern for a single seven-segment digit with its decimal point. The digit shows the magnitude of the number, from 0 to 8. The decimal point serves as the minus sign: it is lit for negative numbers and dark otherwise. A blanking input, `show_en`, replaces the number with a dash whenever it is low.

The driver is purely combinational, and one copy is placed per digit. In a three-number sorter, three copies show the captured inputs and have their enables tied to the start strobe. Three more show the sorted results and have their enables tied to the finish strobe. Scanning between digits and mapping to board pins are handled elsewhere.

Top module: `sseg_signed_digit`

## Requirements
- R1: When `show_en` is 0, `seg_n` is 7'b1111110 (middle segment only) and `dp_n` is 1, whatever `value` holds.
- R2: When `show_en` is 1 and `value[3]` is 1 (negative), `dp_n` is 0.
- R3: When `show_en` is 1 and `value[3]` is 0 (zero or positive), `dp_n` is 1.
- R4: When `show_en` is 1, the digit shown is the magnitude of `value`. The encoding 4'b1000 (-8) shows the digit 8, which is `seg_n` = 7'b0000000.
- R5: 4'b1001 shows the digit 7 (`seg_n` = 7'b0001111) with `dp_n` = 0. 4'b0111 shows the same digit with `dp_n` = 1.
- R6: Segments are active low and ordered `seg_n[6]`=a, [5]=b, [4]=c, [3]=d, [2]=e, [1]=f, [0]=g. Digit patterns: 0=0000001, 1=1001111, 2=0010010, 3=0000110, 4=1001100, 5=0100100, 6=0100000, 7=0001111, 8=0000000.
- R7: The outputs follow the inputs with no clock and no stored state. A new input is visible at the outputs within the same cycle it is applied.
- R8: For every value v from 1 to 7, v and -v produce identical `seg_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| show_en | input | 1 | 1 shows the number, 0 shows a dash |
| value | input | 4 | Two's complement number to display |
| seg_n | output | 7 | Active-low segments a..g, a in bit 6 |
| dp_n | output | 1 | Active-low decimal point, used as minus sign |

## Verification
The hardest case is the lone asymmetric code, 4'b1000. Its negation overflows back to itself, yet it must still read as 8 with the sign lit. A directed sweep covers all 16 codes in both enable states, which forces this code along with the 1001/0111 pair. Seeded random pairs of codes then move between the blanked and shown states mid-run, checking that no earlier input leaves a trace.

// File: rtl/sseg_signed_digit.sv
module sseg_signed_digit #(
  parameter int W = 4
) (
  input  logic         show_en,
  input  logic [W-1:0] value,
  output logic [6:0]   seg_n,
  output logic         dp_n
);
  localparam logic [6:0] DASH_N = 7'b1111110;

  logic         neg;
  logic [W-1:0] mag;
  logic [6:0]   digit_n;

  assign neg = value[W-1];
  assign mag = neg ? (~value + 1'b1) : value;

  always_comb begin
    case (mag)
      4'd0:    digit_n = 7'b0000001;
      4'd1:    digit_n = 7'b1001111;
      4'd2:    digit_n = 7'b0010010;
      4'd3:    digit_n = 7'b0000110;
      4'd4:    digit_n = 7'b1001100;
      4'd5:    digit_n = 7'b0100100;
      4'd6:    digit_n = 7'b0100000;
      4'd7:    digit_n = 7'b0001111;
      4'd8:    digit_n = 7'b0000000;
      default: digit_n = DASH_N;
    endcase
  end

  assign seg_n = show_en ? digit_n : DASH_N;
  assign dp_n  = show_en ? ~neg : 1'b1;
endmodule

// File: rtl/sseg_signed_digit_chk.sv
module sseg_signed_digit_chk (
  input logic       show_en,
  input logic [3:0] value,
  input logic [6:0] seg_n,
  input logic       dp_n
);
  always_comb begin
    if (!show_en) begin
      assert_dash_when_off_R1: assert (seg_n == 7'b1111110 && dp_n);
    end
    if (show_en && value[3]) begin
      assert_sign_lit_R2: assert (!dp_n);
    end
    if (show_en && !value[3]) begin
      assert_sign_dark_R3: assert (dp_n);
    end
    if (show_en && value == 4'b1000) begin
      assert_minus_eight_R4: assert (seg_n == 7'b0000000);
    end
    if (show_en) begin
      assert_never_dash_R6: assert (seg_n != 7'b1111110);
    end
  end
endmodule

bind sseg_signed_digit sseg_signed_digit_chk u_chk (
  .show_en(show_en),
  .value(value),
  .seg_n(seg_n),
  .dp_n(dp_n)
);

// File: tb/sseg_signed_digit_tb.sv
module sseg_signed_digit_tb;
  logic       clk = 0;
  logic       rst = 1;
  logic       show_en;
  logic [3:0] value;
  logic [6:0] seg_n;
  logic       dp_n;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sseg_signed_digit u_dut (.show_en(show_en), .value(value), .seg_n(seg_n), .dp_n(dp_n));

  function automatic logic [6:0] pat(input int m);
    case (m)
      0: return 7'b0000001; 1: return 7'b1001111; 2: return 7'b0010010;
      3: return 7'b0000110; 4: return 7'b1001100; 5: return 7'b0100100;
      6: return 7'b0100000; 7: return 7'b0001111; default: return 7'b0000000;
    endcase
  endfunction

  function automatic logic [7:0] expect_out(input logic en, input logic [3:0] v);
    int s;
    s = v[3] ? int'(v) - 16 : int'(v);
    if (!en) return {7'b1111110, 1'b1};
    return {pat(s < 0 ? -s : s), (s >= 0)};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s en=%b val=%b actual=%b expected=%b", req, show_en, value, act, exp);
    end
  endtask

  task automatic apply(input logic en, input logic [3:0] v, input string req);
    @(posedge clk); #1;
    show_en = en; value = v;
    @(negedge clk);
    check(req, {seg_n, dp_n}, expect_out(en, v));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [6:0] sp;
    int unused;
    show_en = 0; value = 4'b0101;
    repeat (2) @(posedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 idle", {seg_n, dp_n}, {7'b1111110, 1'b1});
    apply(1, 4'b1000, "R4 minus eight");
    check("R4 literal", {seg_n, dp_n}, {7'b0000000, 1'b0});
    apply(1, 4'b1001, "R5 minus seven");
    check("R5 literal", {seg_n, dp_n}, {7'b0001111, 1'b0});
    apply(1, 4'b0111, "R5 plus seven");
    check("R5 literal", {seg_n, dp_n}, {7'b0001111, 1'b1});
    apply(1, 4'b0000, "R3 zero");
    check("R6 zero pattern", {seg_n, dp_n}, {7'b0000001, 1'b1});
    for (int e = 0; e < 2; e++)
      for (int k = 0; k < 16; k++)
        apply(e[0], k[3:0], e == 0 ? "R1 sweep" : (k >= 8 ? "R2 sweep" : "R3 sweep"));
    for (int k = 1; k < 8; k++) begin
      apply(1, k[3:0], "R6 positive");
      sp = seg_n;
      apply(1, 4'(16 - k), "R2 negative");
      checks++;
      if (seg_n !== sp) begin
        failures++;
        $display("FAIL R8 v=%0d actual=%b expected=%b", k, seg_n, sp);
      end
    end
    unused = $urandom(32'h5eed);
    for (int i = 0; i < 300; i++) begin
      logic [3:0] rv = 4'($urandom);
      logic re = 1'($urandom);
      @(posedge clk); #1;
      show_en = re; value = rv;
      #1;
      check("R7 same cycle", {seg_n, dp_n}, expect_out(re, rv));
      @(negedge clk);
      check(re ? "R4 random" : "R1 random", {seg_n, dp_n}, expect_out(re, rv));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule